// File: doc/BRIEF.md
# Model-Specific-Register Exit Filter

This block decides whether a guest instruction that reads or writes a model-specific register must leave guest execution and trap to the hypervisor. A request carries a 32-bit register index and a direction flag. The hypervisor provides two more inputs: an enable for permission bitmaps and the base address of a 4 KB permission region. When the bitmaps are in use and the index falls in one of the two covered windows, the block fetches one byte of the region through a narrow read port. It picks the bit that belongs to the index and reports exit or allow with a one-cycle `done` pulse.

The permission region is split into four 1 KB quarters. The quarter is chosen by direction and by window. Reads of the low window use quarter 0, reads of the high window use quarter 1, writes of the low window use quarter 2, and writes of the high window use quarter 3. A disabled enable, or an index outside both windows, settles the answer as "exit" at once, with no memory traffic.

The controller has four states. IDLE accepts a request. From there it goes to FETCH if a lookup is needed, or straight to DONE if the answer is already forced. FETCH issues the single read and always moves on to WAIT. WAIT holds until read data is valid and then moves to DONE. DONE presents the answer for one cycle and returns to IDLE.

Top module: `msr_exit_filter`

## Requirements
- R1: With `bitmap_en` low at acceptance, `done` is high in the cycle after acceptance with `exit_req`=1, and `mem_rd` is never raised for that request.
- R2: An index outside 0x00000000..0x00001FFF and outside 0xC0000000..0xC0001FFF forces exit in the same way, with no read. 0x00001FFF and 0xC0001FFF are inside the windows; 0x00002000, 0xBFFFFFFF and 0xC0002000 are outside them.
- R3: `mem_addr[11:10]` selects the quarter. It is 0 for a low-window read, 1 for a high-window read, 2 for a low-window write and 3 for a high-window write, which gives byte offsets 0, 1024, 2048 and 3072.
- R4: `mem_addr[9:0]` equals index[12:3]. `mem_addr[ADDR_W-1:12]` equals `bitmap_base[ADDR_W-1:12]`, and the low 12 bits of the base have no effect.
- R5: The answer is bit index[2:0] of the returned byte, where bit 0 is the least significant. A value of 1 gives `exit_req`=1 and a value of 0 gives `exit_req`=0.
- R6: A lookup raises `mem_rd` for exactly one cycle, in the cycle right after acceptance, and exactly once per request.
- R7: `done` is a one-cycle pulse, and `exit_req` is meaningful only while `done` is high. After the read is issued, `done` rises in the cycle after the one in which `mem_rvalid` is sampled high.
- R8: A request is accepted only while `req_ready` is high (IDLE). `req_valid` held while the block is busy starts no second lookup and no second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_index | input | 32 | Register index |
| req_write | input | 1 | 1 = write access, 0 = read access |
| bitmap_en | input | 1 | Permission bitmaps in use |
| bitmap_base | input | ADDR_W | Base of the 4 KB permission region |
| req_ready | output | 1 | High in IDLE; a request is taken when this and req_valid are both high |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| done | output | 1 | One-cycle completion pulse |
| exit_req | output | 1 | 1 = the access must exit; valid with done |

## Verification
A wrong state shows up at the ports within a cycle or two:
- A stray transition into FETCH shows as a `mem_rd` on a forced-exit request.
- Skipping WAIT shows as a `done` that comes before the read data, or a `done` with a stale answer.
- A DONE that does not fall back to IDLE shows as a `done` wider than one cycle, or as `req_ready` staying low.

Because every request is timed from acceptance to `done`, a single cycle of drift in the state sequence is caught on the request where it happens.

// File: rtl/msrf_pkg.sv
package msrf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } msrf_state_e;

    // quarter selection: {write, high_window}
    typedef enum logic [1:0] {
        QTR_RD_LO = 2'd0,
        QTR_RD_HI = 2'd1,
        QTR_WR_LO = 2'd2,
        QTR_WR_HI = 2'd3
    } msrf_qtr_e;

    localparam int unsigned QTR_BYTES  = 1024;
    localparam int unsigned BYTE_OFF_W = $clog2(QTR_BYTES);
    localparam int unsigned BIT_SEL_W  = 3;
    localparam int unsigned WIN_BITS   = BYTE_OFF_W + BIT_SEL_W;
    localparam int unsigned REGION_W   = BYTE_OFF_W + 2;
    localparam logic [31:0] LO_WIN_START = 32'h0000_0000;
    localparam logic [31:0] HI_WIN_START = 32'hC000_0000;

endpackage

// File: rtl/msrf_decode.sv
module msrf_decode
    import msrf_pkg::*;
#(
    parameter int unsigned ADDR_W = 40
) (
    input  logic [31:0]          index,
    input  logic                 write,
    input  logic [ADDR_W-1:0]    base,
    output logic                 in_range,
    output logic [ADDR_W-1:0]    byte_addr,
    output logic [BIT_SEL_W-1:0] bit_sel
);

    localparam int unsigned TAG_W = 32 - WIN_BITS;

    logic      hit_lo;
    logic      hit_hi;
    msrf_qtr_e qtr;

    always_comb begin
        hit_lo   = (index[31:WIN_BITS] == LO_WIN_START[31:WIN_BITS]);
        hit_hi   = (index[31:WIN_BITS] == HI_WIN_START[31:WIN_BITS]);
        in_range = hit_lo || hit_hi;
        qtr      = msrf_qtr_e'({write, hit_hi});
        // base is taken as 4 KB aligned: its low REGION_W bits are dropped
        byte_addr = {base[ADDR_W-1:REGION_W], qtr, index[WIN_BITS-1:BIT_SEL_W]};
        bit_sel   = index[BIT_SEL_W-1:0];
    end

    initial begin
        assert (TAG_W > 0);
        assert (ADDR_W > REGION_W);
    end

endmodule

// File: rtl/msrf_bitsel.sv
module msrf_bitsel #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SEL_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [SEL_W-1:0]  sel,
    output logic              bit_out
);

    logic [DATA_W-1:0] onehot;

    for (genvar i = 0; i < DATA_W; i++) begin : g_sel
        assign onehot[i] = data[i] && (sel == SEL_W'(i));
    end

    assign bit_out = |onehot;

endmodule

// File: rtl/msrf_fsm.sv
module msrf_fsm
    import msrf_pkg::*;
#(
    parameter int unsigned ADDR_W = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 bitmap_en,
    input  logic                 in_range,
    input  logic [ADDR_W-1:0]    addr_in,
    input  logic [BIT_SEL_W-1:0] sel_in,
    input  logic                 mem_rvalid,
    input  logic                 hit,
    output logic                 req_ready,
    output logic                 mem_rd,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BIT_SEL_W-1:0] sel_q,
    output logic                 done,
    output logic                 exit_req
);

    msrf_state_e       state, state_nx;
    logic              accept;
    logic              result_q;
    logic [ADDR_W-1:0] addr_q;

    assign accept = req_valid && (state == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = (bitmap_en && in_range) ? ST_FETCH : ST_DONE;
            ST_FETCH: state_nx = ST_WAIT;
            ST_WAIT:  if (mem_rvalid) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
        endcase
    end

    // captured request and answer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            sel_q    <= '0;
            result_q <= 1'b0;
        end else if (accept) begin
            addr_q   <= addr_in;
            sel_q    <= sel_in;
            result_q <= 1'b1;
        end else if (state == ST_WAIT && mem_rvalid) begin
            result_q <= hit;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_rd    = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_FETCH: mem_rd    = 1'b1;
            ST_WAIT:  ;
            ST_DONE:  done      = 1'b1;
        endcase
        mem_addr = addr_q;
        exit_req = done && result_q;
    end

    assert_forced_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !bitmap_en) |=> (done && exit_req && !mem_rd));

    assert_out_of_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !in_range) |=> (done && !mem_rd));

    assert_read_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && bitmap_en && in_range) |=> mem_rd);

    assert_read_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || done) |-> !req_ready);

endmodule

// File: rtl/msr_exit_filter.sv
module msr_exit_filter
    import msrf_pkg::*;
#(
    parameter int unsigned ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_index,
    input  logic              req_write,
    input  logic              bitmap_en,
    input  logic [ADDR_W-1:0] bitmap_base,
    output logic              req_ready,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic              done,
    output logic              exit_req
);

    logic                 in_range;
    logic [ADDR_W-1:0]    dec_addr;
    logic [BIT_SEL_W-1:0] dec_sel;
    logic [BIT_SEL_W-1:0] sel_q;
    logic                 hit;

    msrf_decode #(.ADDR_W(ADDR_W)) u_decode (
        .index     (req_index),
        .write     (req_write),
        .base      (bitmap_base),
        .in_range  (in_range),
        .byte_addr (dec_addr),
        .bit_sel   (dec_sel)
    );

    msrf_bitsel #(.DATA_W(8), .SEL_W(BIT_SEL_W)) u_bitsel (
        .data    (mem_rdata),
        .sel     (sel_q),
        .bit_out (hit)
    );

    msrf_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .bitmap_en  (bitmap_en),
        .in_range   (in_range),
        .addr_in    (dec_addr),
        .sel_in     (dec_sel),
        .mem_rvalid (mem_rvalid),
        .hit        (hit),
        .req_ready  (req_ready),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .sel_q      (sel_q),
        .done       (done),
        .exit_req   (exit_req)
    );

endmodule

// File: tb/tb_msr_exit_filter.sv
`timescale 1ns/100ps
module tb_msr_exit_filter;

    localparam int AW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_index = '0;
    logic          req_write = 1'b0;
    logic          bitmap_en = 1'b0;
    logic [AW-1:0] bitmap_base = '0;
    logic          req_ready, mem_rd, done, exit_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [7:0]    mem_rdata = 8'hA5;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    msr_exit_filter #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
        .req_write(req_write), .bitmap_en(bitmap_en), .bitmap_base(bitmap_base),
        .req_ready(req_ready), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .exit_req(exit_req)
    );

    function automatic logic [7:0] byte_at(input logic [11:0] off);
        return off[7:0] ^ {off[11:8], off[11:8]} ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // one request from acceptance to done; lat >= 1 cycles of read latency
    task automatic run_req(input logic [31:0] idx, input bit wr, input bit en,
                           input logic [AW-1:0] base, input int lat, input bit hold,
                           output bit got_exit, output int rd_cnt,
                           output logic [AW-1:0] got_addr, output int ncyc);
        int pend;
        @(negedge clk);
        req_index = idx; req_write = wr; bitmap_en = en; bitmap_base = base;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = hold;
        if (hold) req_index = 32'h4000_0000;
        rd_cnt = 0; got_exit = 1'b0; got_addr = '0; ncyc = -1; pend = -1;
        for (int c = 1; c < 60; c++) begin
            mem_rvalid = 1'b0;
            mem_rdata = 8'hFF;
            if (done) begin
                got_exit = exit_req;
                ncyc = c;
                break;
            end
            if (mem_rd) begin
                rd_cnt++;
                got_addr = mem_addr;
                pend = lat;
            end
            if (pend == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata = byte_at(got_addr[11:0]);
                pend = -1;
            end else if (pend > 0) begin
                pend--;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [31:0] idx, input bit wr, input logic [AW-1:0] base);
        logic [AW-1:0] off;
        off = (wr ? 2048 : 0) + (idx[31] ? 1024 : 0) + idx[12:3];
        return (base & ~AW'(12'hFFF)) + off;
    endfunction

    task automatic lookup(input logic [31:0] idx, input bit wr, input logic [AW-1:0] base,
                          input int lat, input string req);
        bit ex; int rc; logic [AW-1:0] a; int n; logic [AW-1:0] ea; bit eb;
        ea = exp_addr(idx, wr, base);
        eb = byte_at(ea[11:0])[idx[2:0]];
        run_req(idx, wr, 1'b1, base, lat, 1'b0, ex, rc, a, n);
        chk(rc == 1, {req, " one read (R6)"}, rc, 1);
        chk(a == ea, {req, " address"}, a, ea);
        chk(ex == eb, {req, " exit bit (R5)"}, ex, eb);
        chk(n == lat + 2, {req, " done timing (R7)"}, n, lat + 2);
    endtask

    task automatic test_reset();
        chk(req_ready == 1'b1, "R8 ready after reset", req_ready, 1);
        chk(done == 1'b0, "R7 done low after reset", done, 0);
        chk(mem_rd == 1'b0, "R6 no read after reset", mem_rd, 0);
    endtask

    task automatic test_disabled();
        bit ex; int rc; logic [AW-1:0] a; int n;
        run_req(32'h0000_0010, 1'b0, 1'b0, 40'h12_3456_7000, 1, 1'b0, ex, rc, a, n);
        chk(ex == 1'b1, "R1 exit when disabled", ex, 1);
        chk(rc == 0, "R1 no read when disabled", rc, 0);
        chk(n == 1, "R1 done next cycle", n, 1);
        run_req(32'hC000_0003, 1'b1, 1'b0, 40'h12_3456_7000, 1, 1'b0, ex, rc, a, n);
        chk(ex == 1'b1 && rc == 0, "R1 exit when disabled, write high", {ex, rc[7:0]}, 9'h100);
    endtask

    task automatic test_out_of_range();
        logic [31:0] outs [4] = '{32'h0000_2000, 32'hBFFF_FFFF, 32'hC000_2000, 32'h4000_0000};
        bit ex; int rc; logic [AW-1:0] a; int n;
        foreach (outs[i]) begin
            run_req(outs[i], i[0], 1'b1, 40'h00_0000_1000, 1, 1'b0, ex, rc, a, n);
            chk(ex == 1'b1, "R2 exit out of range", ex, 1);
            chk(rc == 0 && n == 1, "R2 no read, immediate done", {rc[7:0], n[7:0]}, 16'h0001);
        end
    endtask

    task automatic test_quarters();
        logic [AW-1:0] base = 40'hAB_CDEF_0000;
        lookup(32'h0000_0123, 1'b0, base, 1, "R3 read low");
        lookup(32'hC000_0123, 1'b0, base, 1, "R3 read high");
        lookup(32'h0000_0123, 1'b1, base, 1, "R3 write low");
        lookup(32'hC000_0123, 1'b1, base, 1, "R3 write high");
    endtask

    task automatic test_offsets();
        // base low bits set: must be ignored (R4); window edges included
        lookup(32'h0000_1FFF, 1'b0, 40'h01_0000_0FFF, 2, "R4 low edge");
        lookup(32'hC000_1FFF, 1'b1, 40'h01_0000_0ABC, 1, "R4 high edge");
        lookup(32'h0000_0000, 1'b1, 40'h7F_FFFF_F001, 3, "R4 index zero");
        for (int i = 0; i < 8; i++)
            lookup(32'h0000_0A48 + i, 1'b0, 40'h00_0010_0000, 1, "R5 bit walk");
    endtask

    task automatic test_latency();
        for (int l = 1; l <= 5; l++)
            lookup(32'hC000_0777, l[0], 40'h00_2000_0000, l, "R7 latency");
    endtask

    task automatic test_busy();
        bit ex; int rc; logic [AW-1:0] a; int n; logic [AW-1:0] ea; bit eb;
        ea = exp_addr(32'h0000_0555, 1'b0, 40'h0);
        eb = byte_at(ea[11:0])[3'd5];
        run_req(32'h0000_0555, 1'b0, 1'b1, 40'h0, 3, 1'b1, ex, rc, a, n);
        chk(rc == 1, "R8 single read while held", rc, 1);
        chk(ex == eb, "R8 answer of first request", ex, eb);
        chk(n == 5, "R8 done timing", n, 5);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(!done && !mem_rd, "R8 no second done or read", {done, mem_rd}, 0);
        end
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_disabled();
        test_out_of_range();
        test_quarters();
        test_offsets();
        test_latency();
        test_busy();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule